// File: doc/BRIEF.md
# Folded Symmetric FIR Filter with Interleave Delay Stages

This block is an eight-multiplier FIR filter for 12-bit two's complement samples. The taps are folded: each multiplier is preceded by a pre-add ALU. The ALU combines one word taken from a forward delay path with one word taken from a reverse delay path. The forward path runs from the input through eight delay stages. The output of its last stage feeds the first of eight reverse stages. With a symmetric coefficient set, the eight products therefore cover sixteen taps. With an asymmetric set, one ALU operand is forced to zero and eight taps remain.

Every delay stage holds a programmable number of words, from 1 to 16. When several data sets are interleaved word by word in one stream, setting the stage length to the number of sets makes each tap see only words of its own set. The streams never have to be separated. The same length setting spaces the taps for decimation. A running accumulator after the product sum lets a user spread a long filter over several cycles. The finished total is presented on a 32-bit output register.

Coefficients arrive on a flat input bus, one 12-bit word per multiplier. The delay stages move only on cycles where the hold input is low.

Top module: `symfold_fir`

## Requirements
- R1: A synchronous active-high reset clears every delay-stage word, the running total and the output to zero; `acc_out` reads 0 on the cycle after a reset edge.
- R2: With `len_code`=0 (one word per stage) and mode add (`alu_sub`=0, `zero_a`=0, `zero_b`=0), the value loaded into the running total equals sum over k=0..7 of c[k]*(x[n-1-k] + x[n-16+k]). Here c[k] is `coef` bits [12k+11:12k], and x[n-1] is the newest word shifted in.
- R3: With `alu_sub`=1, each ALU produces B−A, that is c[k]*(x[n-16+k] − x[n-1-k]).
- R4: `zero_a`=1 forces operand A (forward) to 0 and `zero_b`=1 forces operand B (reverse) to 0, giving 8-tap filters on the reverse or forward words alone.
- R5: Stage length is `len_code`+1 words (1..16); for length L, tap k uses the words delayed by (k+1)·L and (16−k)·L shifts.
- R6: The first reverse stage takes its input from the output of the last forward stage.
- R7: While `shift_hold`=1 no delay-stage word changes; shifting resumes where it stopped when `shift_hold` returns to 0.
- R8: On an edge with `acc_en`=1 the running total adds the current product sum and `acc_out` keeps its value.
- R9: On an edge with `acc_en`=0, `acc_out` loads the running total and the running total restarts from the current product sum alone.
- R10: The 13-bit ALU result and the product sum are exact at full scale (all words −2048, all coefficients −2048, add mode gives 67108864).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 12 | Input sample, two's complement |
| coef | input | 96 | Eight 12-bit coefficients, multiplier k at bits [12k+11:12k] |
| len_code | input | 4 | Delay-stage length minus one |
| alu_sub | input | 1 | 0: A+B, 1: B−A |
| zero_a | input | 1 | Force ALU operand A to zero |
| zero_b | input | 1 | Force ALU operand B to zero |
| shift_hold | input | 1 | 1 freezes all delay stages |
| acc_en | input | 1 | 1 accumulates and holds the output register |
| acc_out | output | 32 | Output register, two's complement |

## Verification
The hardest condition to reach is a fully populated reverse path at the longest stage length. There, the deepest reverse word lies 256 shifts behind the input, so every tap pairing is visible only after long runs. The stimulus resets the block, selects length 16, and pushes more than 300 interleaved-pattern words, comparing every cycle against a sample-history model. Hold and accumulate cycles are interleaved in a table run at length 1. This exercises frozen stages together with open accumulation windows.

// File: rtl/symfold_pkg.sv
package symfold_pkg;
    parameter int DW     = 12;
    parameter int CW     = 12;
    parameter int NMUL   = 8;
    parameter int MAXLEN = 16;
    parameter int ACCW   = 32;

    localparam int LENW = $clog2(MAXLEN);
    localparam int ALUW = DW + 1;
    localparam int PW   = ALUW + CW;
    localparam int SUMW = PW + $clog2(NMUL);

    typedef logic signed [DW-1:0]   sample_t;
    typedef logic signed [CW-1:0]   coef_t;
    typedef logic signed [ALUW-1:0] alu_t;
    typedef logic signed [PW-1:0]   prod_t;
    typedef logic signed [SUMW-1:0] psum_t;
    typedef logic signed [ACCW-1:0] acc_t;

    typedef struct packed {
        logic sub;
        logic zero_a;
        logic zero_b;
    } alu_cfg_t;

    function automatic alu_t fold_words(sample_t a, sample_t b, alu_cfg_t cfg);
        alu_t ea;
        alu_t eb;
        ea = cfg.zero_a ? '0 : ALUW'(a);
        eb = cfg.zero_b ? '0 : ALUW'(b);
        return cfg.sub ? (eb - ea) : (ea + eb);
    endfunction
endpackage

// File: rtl/symfold_delay_stage.sv
module symfold_delay_stage
    import symfold_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic [LENW-1:0] len_code,
    input  sample_t         d_in,
    output sample_t         d_out
);
    sample_t words [MAXLEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MAXLEN; i++) words[i] <= '0;
        end else if (shift_en) begin
            words[0] <= d_in;
            for (int i = 1; i < MAXLEN; i++) words[i] <= words[i-1];
        end
    end

    assign d_out = words[len_code];
endmodule

// File: rtl/symfold_tap.sv
module symfold_tap
    import symfold_pkg::*;
(
    input  sample_t  fwd_word,
    input  sample_t  rev_word,
    input  coef_t    weight,
    input  alu_cfg_t cfg,
    output prod_t    product
);
    alu_t folded;

    always_comb begin
        folded  = fold_words(fwd_word, rev_word, cfg);
        product = PW'(folded) * PW'(weight);
    end
endmodule

// File: rtl/symfold_accum.sv
module symfold_accum
    import symfold_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_en,
    input  psum_t psum,
    output acc_t  running,
    output acc_t  held
);
    acc_t psum_ext;

    assign psum_ext = ACCW'(psum);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= '0;
            held    <= '0;
        end else if (acc_en) begin
            running <= running + psum_ext;
        end else begin
            held    <= running;
            running <= psum_ext;
        end
    end
endmodule

// File: rtl/symfold_fir.sv
module symfold_fir
    import symfold_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DW-1:0]        din,
    input  logic [NMUL*CW-1:0]   coef,
    input  logic [LENW-1:0]      len_code,
    input  logic                 alu_sub,
    input  logic                 zero_a,
    input  logic                 zero_b,
    input  logic                 shift_hold,
    input  logic                 acc_en,
    output logic [ACCW-1:0]      acc_out
);
    alu_cfg_t cfg;
    sample_t  fwd_tap [NMUL];
    sample_t  rev_tap [NMUL];
    prod_t    prods   [NMUL];
    psum_t    psum;
    acc_t     running;
    acc_t     held;
    logic     shift_en;

    assign cfg      = '{sub: alu_sub, zero_a: zero_a, zero_b: zero_b};
    assign shift_en = ~shift_hold;

    genvar k;
    generate
        for (k = 0; k < NMUL; k++) begin : g_lane
            sample_t fwd_src;
            sample_t rev_src;
            if (k == 0) begin : g_head
                assign fwd_src = sample_t'(din);
            end else begin : g_mid
                assign fwd_src = fwd_tap[k-1];
            end
            if (k == NMUL-1) begin : g_turn
                assign rev_src = fwd_tap[NMUL-1];
            end else begin : g_back
                assign rev_src = rev_tap[k+1];
            end

            symfold_delay_stage u_fwd (
                .clk(clk), .rst(rst), .shift_en(shift_en),
                .len_code(len_code), .d_in(fwd_src), .d_out(fwd_tap[k])
            );
            symfold_delay_stage u_rev (
                .clk(clk), .rst(rst), .shift_en(shift_en),
                .len_code(len_code), .d_in(rev_src), .d_out(rev_tap[k])
            );
            symfold_tap u_tap (
                .fwd_word(fwd_tap[k]), .rev_word(rev_tap[k]),
                .weight(coef_t'(coef[k*CW +: CW])), .cfg(cfg),
                .product(prods[k])
            );
        end
    endgenerate

    always_comb begin
        psum = '0;
        for (int i = 0; i < NMUL; i++) psum = psum + SUMW'(prods[i]);
    end

    symfold_accum u_acc (
        .clk(clk), .rst(rst), .acc_en(acc_en), .psum(psum),
        .running(running), .held(held)
    );

    assign acc_out = held;
endmodule

// File: rtl/symfold_fir_chk.sv
module symfold_fir_chk
    import symfold_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            shift_hold,
    input logic            acc_en,
    input logic [LENW-1:0] len_code,
    input logic [DW-1:0]   din,
    input logic [DW-1:0]   fwd_first,
    input logic [DW-1:0]   fwd_last,
    input logic [DW-1:0]   rev_first,
    input logic [ACCW-1:0] running,
    input logic [ACCW-1:0] acc_out
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_q && !rst) begin
            reset_clear_chk: assert (acc_out == '0);
        end
    end

    // R7
    stages_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        shift_hold |=> ($stable(fwd_first) && $stable(rev_first)));

    // R5
    unit_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_hold && len_code == '0) |=> (fwd_first == $past(din)));

    // R6
    fold_link_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_hold && len_code == '0) |=> (rev_first == $past(fwd_last)));

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> $stable(acc_out));

    // R9
    out_load_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> (acc_out == $past(running)));
endmodule

bind symfold_fir symfold_fir_chk u_chk (
    .clk(clk), .rst(rst), .shift_hold(shift_hold), .acc_en(acc_en),
    .len_code(len_code), .din(din),
    .fwd_first(fwd_tap[0]), .fwd_last(fwd_tap[NMUL-1]),
    .rev_first(rev_tap[NMUL-1]), .running(running), .acc_out(acc_out)
);

// File: tb/test_symfold_fir.sv
module test_symfold_fir;
    localparam int NM   = 8;
    localparam int HIST = 2 * NM * 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] din;
    logic [95:0] coef;
    logic [3:0]  len_code;
    logic        alu_sub, zero_a, zero_b, shift_hold, acc_en;
    logic [31:0] acc_out;

    int checks = 0;
    int fails  = 0;
    int hist [HIST];
    int cw   [NM];
    int run_m, out_m;
    bit done = 0;

    // stimulus table: {din[15:4], hold[3], acc[2], spare[1:0]}
    localparam logic [15:0] VEC [20] = '{
        {12'd5, 4'b0000},    {12'd17, 4'b0000},  {12'hFF0, 4'b0000},
        {12'd100, 4'b0000},  {12'd3, 4'b1000},   {12'd9, 4'b1000},
        {12'h800, 4'b0000},  {12'h7FF, 4'b0000}, {12'd40, 4'b0100},
        {12'd41, 4'b0100},   {12'd42, 4'b0100},  {12'd43, 4'b0000},
        {12'hF00, 4'b1100},  {12'd7, 4'b0000},   {12'd1, 4'b0000},
        {12'd2, 4'b0000},    {12'h123, 4'b0000}, {12'd0, 4'b0100},
        {12'd77, 4'b0000},   {12'd8, 4'b0000}
    };

    symfold_fir i_symfold_fir (
        .clk(clk), .rst(rst), .din(din), .coef(coef), .len_code(len_code),
        .alu_sub(alu_sub), .zero_a(zero_a), .zero_b(zero_b),
        .shift_hold(shift_hold), .acc_en(acc_en), .acc_out(acc_out)
    );

    always #10 clk = ~clk;

    function automatic int model_psum();
        int s = 0;
        int len = int'(len_code) + 1;
        for (int k = 0; k < NM; k++) begin
            int a = zero_a ? 0 : hist[(k + 1) * len - 1];
            int b = zero_b ? 0 : hist[(2 * NM - k) * len - 1];
            s += cw[k] * (alu_sub ? (b - a) : (a + b));
        end
        return s;
    endfunction

    task automatic set_coefs(input int base, input int stepv);
        for (int k = 0; k < NM; k++) begin
            cw[k] = base + stepv * k;
            coef[k*12 +: 12] = 12'(cw[k]);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        for (int i = 0; i < HIST; i++) hist[i] = 0;
        run_m = 0;
        out_m = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input int x, input bit hold, input bit acc);
        int p;
        din = 12'(x);
        shift_hold = hold;
        acc_en = acc;
        @(posedge clk);
        p = model_psum();
        if (!acc) begin
            out_m = run_m;
            run_m = p;
        end else begin
            run_m = run_m + p;
        end
        if (!hold) begin
            for (int i = HIST - 1; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = (x >= 2048) ? x - 4096 : x;
        end
        @(negedge clk);
    endtask

    task automatic check(input string req, input int expv);
        checks++;
        if ($signed(acc_out) !== expv) begin
            fails++;
            $display("FAIL %s: acc_out=%0d expected=%0d", req, $signed(acc_out), expv);
        end
    endtask

    task automatic run_checked(input string req, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            int x = ((seed * (i + 3) * 37 + i * i * 11) % 4096) - 2048;
            step(x, 1'b0, 1'b0);
            check(req, out_m);
        end
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        din = '0; coef = '0; len_code = '0;
        alu_sub = 0; zero_a = 0; zero_b = 0; shift_hold = 0; acc_en = 0;
        @(negedge clk);
        set_coefs(1, 1);
        do_reset();
        check("R1", 0);

        // table walk at length 1: R2 data, R7 hold rows, R8/R9 accumulate rows
        for (int v = 0; v < 20; v++) begin
            step(int'(VEC[v][15:4]), VEC[v][3], VEC[v][2]);
            check(VEC[v][2] ? "R8" : (VEC[v][3] ? "R7" : "R2"), out_m);
        end

        // R6: impulse walks forward then back through the fold
        do_reset();
        step(1, 0, 0);
        for (int i = 0; i < 20; i++) begin
            step(0, 0, 0);
            check("R6", out_m);
        end

        // R7: hold keeps stages; released run continues
        for (int i = 0; i < 4; i++) begin
            step(999, 1, 0);
            check("R7", out_m);
        end

        // R9: open then close accumulation window
        step(12, 0, 1); check("R8", out_m);
        step(13, 0, 1); check("R8", out_m);
        step(14, 0, 0); check("R9", out_m);
        step(15, 0, 0); check("R9", out_m);

        run_checked("R2", 24, 5);
        alu_sub = 1;
        run_checked("R3", 24, 7);
        alu_sub = 0; zero_b = 1;
        run_checked("R4", 24, 11);
        zero_b = 0; zero_a = 1;
        run_checked("R4", 24, 13);
        zero_a = 0;

        // R5: longest stages, reset after length change
        set_coefs(-3, 2);
        len_code = 4'd15;
        do_reset();
        run_checked("R5", 300, 17);
        len_code = 4'd2;
        do_reset();
        run_checked("R5", 70, 19);

        // R10: full scale
        len_code = 4'd0;
        set_coefs(-2048, 0);
        do_reset();
        for (int i = 0; i < 20; i++) step(-2048, 0, 0);
        check("R10", 67108864);
        check("R10", out_m);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule